// File: doc/BRIEF.md
# Dual-Clock Control and Status Register Bank

This block is the software-facing register bank for one streaming data engine. A word-addressed register port (address, write enable, write data, read data) runs on the control clock. Through it software sets a reset bit and a run-enable bit, a frame length, an iteration count and a memory wrap address. It reads back a fixed identifier and a completion flag. The engine runs on a data clock four times faster than the control clock. Every control value the engine sees is delivered in that clock, and the engine's completion flag is carried back to the control clock.

Each single-bit signal crosses through its own two-flop synchronizer. The three multi-bit fields do not use a handshake. The data domain keeps a shadow copy of them that follows the control registers only while the synchronized run-enable is low, and it freezes the copy while the engine runs. Software is expected to program the fields before raising the run bit.

Top module: `regbank_xdomain`

## Requirements
- R1: After reset, every writable register is zero. `eng_rst`, `eng_run`, `eng_frame_len`, `eng_iter_cnt` and `eng_wrap_addr` read zero, and offset 0x20 reads zero.
- R2: Byte offset 0x00 reads the parameter `ID_VALUE`, and writes to 0x00 have no effect on it.
- R3: At offset 0x04, write data bit 0 drives `eng_rst` and bit 1 drives `eng_run`. Each reaches its engine pin through a two-flop synchronizer on `dat_clk`, and is seen within three control-clock cycles of the write.
- R4: Bits [11:0] of a write to offset 0x08 set `eng_frame_len`. Upper write bits are discarded.
- R5: Bits [11:0] of a write to offset 0x0C set `eng_iter_cnt`. Upper write bits are discarded.
- R6: Bits [15:0] of a write to offset 0x10 set `eng_wrap_addr`. Upper write bits are discarded.
- R7: While the synchronized run bit is high, `eng_frame_len`, `eng_iter_cnt` and `eng_wrap_addr` hold their value even if the registers are rewritten. Once run is low again, the engine pins take the new values.
- R8: Offset 0x20 reads `eng_done`, synchronized into the control clock, in bit 0, with bits [31:1] zero. Writes to 0x20 are ignored, including a write that lands while the flag is rising.
- R9: Reads of write-only offsets (0x04, 0x08, 0x0C, 0x10) return zero. So do reads of any other offset, including misaligned ones.
- R10: `reg_rdata` is registered. It shows the value addressed at the previous rising `ctl_clk` edge and is zero while `ctl_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Control (register port) clock |
| ctl_rst_n | input | 1 | Synchronous active-low reset, control domain |
| reg_addr | input | ADDR_W (8) | Byte offset of the accessed register |
| reg_wr_en | input | 1 | Write strobe for one cycle |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Registered read data |
| dat_clk | input | 1 | Engine clock, four times the control clock |
| dat_rst_n | input | 1 | Synchronous active-low reset, data domain |
| eng_rst | output | 1 | Engine reset request |
| eng_run | output | 1 | Engine run enable |
| eng_frame_len | output | 12 | Words per frame |
| eng_iter_cnt | output | 12 | Number of passes |
| eng_wrap_addr | output | 16 | Address at which reads wrap to zero |
| eng_done | input | 1 | Engine completion flag, data domain |

## Verification
Two events can meet in one control cycle: the completion flag arriving through its synchronizer, and a software write aimed at the read-only status offset. The bench raises `eng_done` on the same control cycle in which it writes zero to 0x20. It then reads 0x20 and expects 1, which shows the write did not clear or mask the flag. A second overlap is a field write while the engine runs. That write must be invisible at the engine pins until run is dropped, and this is judged at the pins before and after the stop.

// File: rtl/regbank_pkg.sv
// Package: shared widths, register offsets and the control bundle type
// for the dual-clock register bank. Offsets are byte addresses.
package regbank_pkg;

    localparam int FRAME_W = 12;
    localparam int ITER_W  = 12;
    localparam int WRAP_W  = 16;

    // Byte offsets of the register map
    localparam logic [7:0] OFF_ID    = 8'h00;
    localparam logic [7:0] OFF_CTRL  = 8'h04;
    localparam logic [7:0] OFF_FRAME = 8'h08;
    localparam logic [7:0] OFF_ITER  = 8'h0C;
    localparam logic [7:0] OFF_WRAP  = 8'h10;
    localparam logic [7:0] OFF_DONE  = 8'h20;

    // Bit positions inside the control word
    localparam int BIT_RST = 0;
    localparam int BIT_RUN = 1;

    // Multi-bit fields that cross as one held bundle
    localparam int FIELDS_W = FRAME_W + ITER_W + WRAP_W;

    typedef struct packed {
        logic               rst;
        logic               run;
        logic [FRAME_W-1:0] frame_len;
        logic [ITER_W-1:0]  iter_cnt;
        logic [WRAP_W-1:0]  wrap_addr;
    } ctl_regs_t;

endpackage

// File: rtl/regbank_bit_sync.sv
// Module: regbank_bit_sync
// Multi-flop synchronizer for one level signal entering the clk domain.
// Assumes the input is a slowly changing level (held for several clk
// cycles); pulses shorter than a destination period may be lost.
module regbank_bit_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];

    // Cycles since reset, saturating, so the delay check never reaches
    // back into reset
    localparam int WARM_W = $clog2(STAGES + 1);
    logic [WARM_W-1:0] warm_q;

    // Count warm-up cycles after reset for the checker below
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= '0;
        end else if (warm_q != WARM_W'(STAGES)) begin
            warm_q <= warm_q + 1'b1;
        end
    end

    generate
        if (STAGES == 2) begin : g_chk2
            // R3: output is the input delayed by exactly two clk edges
            p_two_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (warm_q == WARM_W'(STAGES)) |-> (q == $past(d, 2)));
        end
    endgenerate

endmodule

// File: rtl/regbank_field_hold.sv
// Module: regbank_field_hold
// Data-domain shadow of the multi-bit control fields. The shadow follows
// its input only while the synchronized run bit is low and freezes while
// it is high. Assumes software changes fields only while run is low, so
// the source bits are quiet whenever the shadow freezes.
module regbank_field_hold #(
    parameter int WIDTH = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_sync,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Refresh the shadow copy while the engine is idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (!run_sync) begin
            q <= d;
        end
    end

    // R7: the shadow never moves while run was high at the previous edge
    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run_sync)) |-> $stable(q));

    // R7: while idle the shadow tracks its source one edge later
    p_refresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(run_sync)) |-> (q == $past(d)));

endmodule

// File: rtl/regbank_ctl_regs.sv
// Module: regbank_ctl_regs
// Control-domain register file: decodes byte offsets, stores the writable
// fields, and produces registered read data. Assumes one access per cycle
// and that done_sync is already synchronized to clk.
module regbank_ctl_regs
    import regbank_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter int              DATA_W   = 32,
    parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done_sync,
    output ctl_regs_t         regs,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(OFF_ID);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_FRAME = ADDR_W'(OFF_FRAME);
    localparam logic [ADDR_W-1:0] A_ITER  = ADDR_W'(OFF_ITER);
    localparam logic [ADDR_W-1:0] A_WRAP  = ADDR_W'(OFF_WRAP);
    localparam logic [ADDR_W-1:0] A_DONE  = ADDR_W'(OFF_DONE);

    ctl_regs_t         regs_q;
    logic [DATA_W-1:0] rd_next;
    logic              unused_wdata;

    // Write bits that no field stores
    assign unused_wdata = ^wdata[DATA_W-1:WRAP_W];

    // Store writable fields; read-only and unmapped offsets drop the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    regs_q.rst <= wdata[BIT_RST];
                    regs_q.run <= wdata[BIT_RUN];
                end
                A_FRAME: regs_q.frame_len <= wdata[FRAME_W-1:0];
                A_ITER:  regs_q.iter_cnt  <= wdata[ITER_W-1:0];
                A_WRAP:  regs_q.wrap_addr <= wdata[WRAP_W-1:0];
                default: ;
            endcase
        end
    end

    // Select read data; write-only and unmapped offsets read zero
    always_comb begin
        case (addr)
            A_ID:    rd_next = ID_VALUE;
            A_DONE:  rd_next = {{(DATA_W-1){1'b0}}, done_sync};
            default: rd_next = '0;
        endcase
    end

    // Register the read data for one-cycle read latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= rd_next;
        end
    end

    assign regs = regs_q;

    // R2: identifier comes back one cycle after it is addressed
    p_id_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(addr) == A_ID)) |-> (rdata == ID_VALUE));

    // R2, R8: writes to read-only offsets leave every stored field untouched
    p_ro_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((addr == A_ID) || (addr == A_DONE))) |=> $stable(regs_q));

    // R8: status read shows the synchronized flag with upper bits clear
    p_done_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(addr) == A_DONE)) |->
        ((rdata[DATA_W-1:1] == '0) && (rdata[0] == $past(done_sync))));

    // R9: every other offset reads zero
    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(addr) != A_ID) && ($past(addr) != A_DONE))
        |-> (rdata == '0));

endmodule

// File: rtl/regbank_xdomain.sv
// Module: regbank_xdomain (top)
// Register bank for one streaming engine. The register port sits on
// ctl_clk; engine controls are delivered on dat_clk and the done flag is
// returned to ctl_clk. Assumes the two clocks are unrelated for timing
// purposes and that fields are programmed while run is low.
module regbank_xdomain
    import regbank_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 32,
    parameter logic [DATA_W-1:0] ID_VALUE    = 32'h5EB1_0A7C,
    parameter int                SYNC_STAGES = 2
) (
    input  logic               ctl_clk,
    input  logic               ctl_rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr_en,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               dat_clk,
    input  logic               dat_rst_n,
    output logic               eng_rst,
    output logic               eng_run,
    output logic [FRAME_W-1:0] eng_frame_len,
    output logic [ITER_W-1:0]  eng_iter_cnt,
    output logic [WRAP_W-1:0]  eng_wrap_addr,
    input  logic               eng_done
);

    localparam int N_CTL_BITS = 2;

    ctl_regs_t               regs;
    logic                    done_sync;
    logic [N_CTL_BITS-1:0]   ctl_bits;
    logic [N_CTL_BITS-1:0]   ctl_bits_sync;
    logic [FIELDS_W-1:0]     fields_src;
    logic [FIELDS_W-1:0]     fields_dat;

    regbank_ctl_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .ID_VALUE (ID_VALUE)
    ) u_regs (
        .clk       (ctl_clk),
        .rst_n     (ctl_rst_n),
        .addr      (reg_addr),
        .wr_en     (reg_wr_en),
        .wdata     (reg_wdata),
        .done_sync (done_sync),
        .regs      (regs),
        .rdata     (reg_rdata)
    );

    // Single-bit controls, index 0 = reset, index 1 = run
    assign ctl_bits = {regs.run, regs.rst};

    generate
        for (genvar i = 0; i < N_CTL_BITS; i++) begin : g_ctl_sync
            regbank_bit_sync #(
                .STAGES    (SYNC_STAGES),
                .RESET_VAL (1'b0)
            ) u_sync (
                .clk   (dat_clk),
                .rst_n (dat_rst_n),
                .d     (ctl_bits[i]),
                .q     (ctl_bits_sync[i])
            );
        end
    endgenerate

    assign eng_rst = ctl_bits_sync[0];
    assign eng_run = ctl_bits_sync[1];

    // Status flag back into the control clock
    regbank_bit_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b0)
    ) u_done_sync (
        .clk   (ctl_clk),
        .rst_n (ctl_rst_n),
        .d     (eng_done),
        .q     (done_sync)
    );

    // Multi-bit fields held in the data domain while the engine runs
    assign fields_src = {regs.frame_len, regs.iter_cnt, regs.wrap_addr};

    regbank_field_hold #(
        .WIDTH (FIELDS_W)
    ) u_hold (
        .clk      (dat_clk),
        .rst_n    (dat_rst_n),
        .run_sync (eng_run),
        .d        (fields_src),
        .q        (fields_dat)
    );

    assign eng_frame_len = fields_dat[FIELDS_W-1 -: FRAME_W];
    assign eng_iter_cnt  = fields_dat[WRAP_W +: ITER_W];
    assign eng_wrap_addr = fields_dat[WRAP_W-1:0];

    // R7: engine fields stay put on consecutive running edges
    p_run_fields_hold_r7: assert property (@(posedge dat_clk) disable iff (!dat_rst_n)
        ($past(dat_rst_n) && $past(eng_run) && eng_run) |->
        ($stable(eng_frame_len) && $stable(eng_iter_cnt) && $stable(eng_wrap_addr)));

endmodule

// File: tb/regbank_xdomain_tb_top.sv
`timescale 1ns/1ps
// Directed bench for regbank_xdomain: one task per scenario, each task
// checks its own results at the ports.
module regbank_xdomain_tb_top;

    localparam logic [31:0] TB_ID = 32'hC0DE_1234;

    logic        ctl_clk = 1'b0;
    logic        dat_clk = 1'b0;
    logic        ctl_rst_n = 1'b0;
    logic        dat_rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_rst;
    logic        eng_run;
    logic [11:0] eng_frame_len;
    logic [11:0] eng_iter_cnt;
    logic [15:0] eng_wrap_addr;
    logic        eng_done = 1'b0;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5    ctl_clk = ~ctl_clk;
    always #1.25 dat_clk = ~dat_clk;

    regbank_xdomain #(
        .ID_VALUE (TB_ID)
    ) dut_i (
        .ctl_clk       (ctl_clk),
        .ctl_rst_n     (ctl_rst_n),
        .reg_addr      (reg_addr),
        .reg_wr_en     (reg_wr_en),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .dat_clk       (dat_clk),
        .dat_rst_n     (dat_rst_n),
        .eng_rst       (eng_rst),
        .eng_run       (eng_run),
        .eng_frame_len (eng_frame_len),
        .eng_iter_cnt  (eng_iter_cnt),
        .eng_wrap_addr (eng_wrap_addr),
        .eng_done      (eng_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge ctl_clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        @(negedge ctl_clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge ctl_clk);
        reg_addr  = a;
        reg_wr_en = 1'b0;
        @(negedge ctl_clk);
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge ctl_clk);
    endtask

    task automatic apply_reset();
        @(negedge ctl_clk);
        ctl_rst_n = 1'b0;
        dat_rst_n = 1'b0;
        reg_addr  = 8'h00;
        repeat (3) @(negedge ctl_clk);
        // R10: read data is zero while reset is held
        chk("R10 rdata in reset", reg_rdata, 32'h0);
        ctl_rst_n = 1'b1;
        dat_rst_n = 1'b1;
        settle();
    endtask

    // R1: reset state at the ports
    task automatic t_reset_state();
        logic [31:0] v;
        chk("R1 eng_rst", {31'h0, eng_rst}, 32'h0);
        chk("R1 eng_run", {31'h0, eng_run}, 32'h0);
        chk("R1 frame", {20'h0, eng_frame_len}, 32'h0);
        chk("R1 iter", {20'h0, eng_iter_cnt}, 32'h0);
        chk("R1 wrap", {16'h0, eng_wrap_addr}, 32'h0);
        rd(8'h20, v);
        chk("R1 done", v, 32'h0);
    endtask

    // R2: identifier readback and ignored write
    task automatic t_id();
        logic [31:0] v;
        rd(8'h00, v);
        chk("R2 id read", v, TB_ID);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v);
        chk("R2 id after write", v, TB_ID);
        chk("R2 write to id leaves fields", {20'h0, eng_frame_len}, 32'h0);
    endtask

    // R3: reset and run bits reach the engine
    task automatic t_ctrl_bits();
        wr(8'h04, 32'h1);
        settle();
        chk("R3 rst only: rst", {31'h0, eng_rst}, 32'h1);
        chk("R3 rst only: run", {31'h0, eng_run}, 32'h0);
        wr(8'h04, 32'h3);
        repeat (3) @(negedge ctl_clk);
        chk("R3 both: rst", {31'h0, eng_rst}, 32'h1);
        chk("R3 both: run", {31'h0, eng_run}, 32'h1);
        wr(8'h04, 32'hFFFF_FFF2);
        settle();
        chk("R3 run only: rst", {31'h0, eng_rst}, 32'h0);
        chk("R3 run only: run", {31'h0, eng_run}, 32'h1);
        wr(8'h04, 32'h0);
        settle();
        chk("R3 cleared: run", {31'h0, eng_run}, 32'h0);
    endtask

    // R4, R5, R6: field widths and truncation
    task automatic t_fields();
        wr(8'h08, 32'hFFFF_F5A5);
        wr(8'h0C, 32'h0000_1777);
        wr(8'h10, 32'hDEAD_BEEF);
        settle();
        chk("R4 frame_len", {20'h0, eng_frame_len}, 32'h5A5);
        chk("R5 iter_cnt", {20'h0, eng_iter_cnt}, 32'h777);
        chk("R6 wrap_addr", {16'h0, eng_wrap_addr}, 32'hBEEF);
    endtask

    // R7: fields frozen while running, refreshed after stop
    task automatic t_freeze();
        wr(8'h04, 32'h2);
        settle();
        wr(8'h08, 32'h0000_0123);
        wr(8'h10, 32'h0000_4242);
        settle();
        chk("R7 frame frozen", {20'h0, eng_frame_len}, 32'h5A5);
        chk("R7 wrap frozen", {16'h0, eng_wrap_addr}, 32'hBEEF);
        wr(8'h04, 32'h0);
        settle();
        chk("R7 frame refreshed", {20'h0, eng_frame_len}, 32'h123);
        chk("R7 wrap refreshed", {16'h0, eng_wrap_addr}, 32'h4242);
    endtask

    // R8: done flag, including a write landing as it rises
    task automatic t_done();
        logic [31:0] v;
        @(negedge ctl_clk);
        eng_done  = 1'b1;
        reg_addr  = 8'h20;
        reg_wdata = 32'h0;
        reg_wr_en = 1'b1;
        @(negedge ctl_clk);
        reg_wr_en = 1'b0;
        settle();
        rd(8'h20, v);
        chk("R8 done set despite write", v, 32'h1);
        eng_done = 1'b0;
        settle();
        rd(8'h20, v);
        chk("R8 done cleared", v, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, v);
        chk("R8 write ignored", v, 32'h0);
    endtask

    // R9: write-only and unmapped offsets read zero
    task automatic t_unmapped();
        logic [31:0] v;
        wr(8'h04, 32'h3);
        rd(8'h04, v);
        chk("R9 ctrl reads zero", v, 32'h0);
        rd(8'h08, v);
        chk("R9 frame reads zero", v, 32'h0);
        rd(8'h10, v);
        chk("R9 wrap reads zero", v, 32'h0);
        rd(8'h14, v);
        chk("R9 hole reads zero", v, 32'h0);
        rd(8'h01, v);
        chk("R9 misaligned reads zero", v, 32'h0);
        wr(8'h04, 32'h0);
        settle();
    endtask

    // R10: one-cycle registered read latency, back-to-back addresses
    task automatic t_latency();
        eng_done = 1'b1;
        settle();
        @(negedge ctl_clk);
        reg_addr = 8'h00;
        @(negedge ctl_clk);
        chk("R10 first read", reg_rdata, TB_ID);
        reg_addr = 8'h20;
        @(negedge ctl_clk);
        chk("R10 next read", reg_rdata, 32'h1);
        reg_addr = 8'h0C;
        @(negedge ctl_clk);
        chk("R10 third read", reg_rdata, 32'h0);
        eng_done = 1'b0;
        settle();
    endtask

    // R1: reset in the middle of activity clears everything
    task automatic t_mid_reset();
        wr(8'h08, 32'h0000_0ABC);
        wr(8'h04, 32'h3);
        settle();
        apply_reset();
        t_reset_state();
    endtask

    initial begin
        apply_reset();
        t_reset_state();
        t_id();
        t_ctrl_bits();
        t_fields();
        t_freeze();
        t_done();
        t_unmapped();
        t_latency();
        t_mid_reset();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge ctl_clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule